// File: doc/BRIEF.md
# Shuttle Printer Scan Line Assembler

This block builds one print line for a drum printer that has no line memory of its own and whose carriage shuttles sideways. The host repeats a scan of the line once for every drum row, and does this twice: once with the carriage on its first side and once on its second. Each 16-bit word carries the codes for two neighbouring columns. The block keeps a character only when its 6-bit code equals the drum row now under the hammers. Characters from the first carriage side fill the even-numbered columns and those from the second side fill the odd-numbered ones.

The block keeps three counters: the word within a scan, the drum row and the carriage side. When the drum row wraps, the carriage side flips and a one-cycle shuttle pulse is raised. When the pass on the second side ends, the block finds the rightmost non-blank column. It streams the columns from the left edge up to that column as 7-bit characters over a valid/ready interface, and marks the final one. It then treats the whole line as blank again and raises print-done. The host interface does not take words while the line is being streamed.

Top module: `shuttle_line_asm`

## Requirements
- R1: While `rst` is high, `word_ready` is 0, `print_done` is 1, `out_valid` is 0, `drum_row` is 0, `carriage` is 0 and every column reads as blank. `word_ready` is 1 in the first cycle after `rst` falls.
- R2: A word is taken at a clock edge where `word_valid` and `word_ready` are both 1. In the next cycle `word_skip` is 1 for one cycle and `word_ready` is 0. A word offered while `word_ready` is 0 is ignored.
- R3: With `carriage` = 0 the character code is `word_data[13:8]`. With `carriage` = 1 it is `word_data[5:0]`. The code goes to column 2 × (word index in the scan) + `carriage`, and columns are numbered from 0 at the left.
- R4: A code is stored only when it equals the current `drum_row`. A code that does not equal the current row leaves its column unchanged.
- R5: A stored code below octal 040 is emitted with bit 6 set (code | 0o100). A stored code of 0o40 or above is emitted unchanged. Blank is 0o040.
- R6: The word index counts 0 to LINE_COLS/2−1. `drum_row` advances after the last word of a scan. After row DRUM_ROWS−1 the row returns to 0, `carriage` toggles and `shuttle_req` is 1 for one cycle.
- R7: When the scan that wraps the drum row with `carriage` = 1 is taken, the block emits columns 0 up to the rightmost non-blank column, with `out_last` = 1 on the final one only. A line with no stored character emits nothing.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold. `word_ready` stays 0 from the end of the line until its last character is accepted.
- R9: `print_done` falls at the first word taken for a line. It rises when the last character is accepted, or one cycle after the line ends if the line is empty. The next line starts fully blank.
- R10: The last word of a line can store a character in the same cycle that it ends the line, and that character is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Host offers a word |
| word_data | input | 16 | Two character codes, in bits 13:8 and 5:0 |
| word_ready | output | 1 | Block will take a word at the next edge |
| word_skip | output | 1 | One-cycle acknowledge of a taken word |
| drum_row | output | ROW_W (6) | Current drum row |
| carriage | output | 1 | Current carriage side |
| shuttle_req | output | 1 | One-cycle pulse on each drum wrap |
| print_done | output | 1 | No line is in progress |
| out_valid | output | 1 | Output character valid |
| out_data | output | 7 | Output character |
| out_last | output | 1 | Final character of the line |
| out_ready | input | 1 | Downstream accepts the character |

## Verification
The taken word that finishes the second carriage pass does two things in one cycle. It may store a character, and it also starts the line end: the trailing-blank search and the streaming. The bench provokes this with a line whose only character sits in the rightmost odd column and matches the last drum row. It then checks that this character comes out as the last byte of the stream. The bench also offers words all through the streaming and checks that none is acknowledged. Throughout, downstream backpressure holds every third output cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int CODE_W = 6;
  localparam int CHAR_W = 7;
  localparam logic [CHAR_W-1:0] BLANK = 7'o040;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_TRIM,
    ST_FETCH,
    ST_LOAD,
    ST_HOLD
  } asm_state_t;

  // Codes below 0o40 gain bit 6 to become printable.
  function automatic logic [CHAR_W-1:0] to_print(input logic [CODE_W-1:0] c);
    return (c < 6'o40) ? {1'b1, c} : {1'b0, c};
  endfunction
endpackage

// File: rtl/slp_line_ram.sv
module slp_line_ram #(
  parameter int DEPTH = 120,
  parameter int AW    = 7,
  parameter int DW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/slp_scan_ctr.sv
module slp_scan_ctr #(
  parameter int SCAN_WORDS = 60,
  parameter int DRUM_ROWS  = 64,
  parameter int WORD_W     = 6,
  parameter int ROW_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [WORD_W-1:0] word_idx,
  output logic [ROW_W-1:0]  row,
  output logic              side,
  output logic              line_end,
  output logic              shuttle_req
);
  logic scan_last, row_last, row_wrap;

  assign scan_last = (word_idx == WORD_W'(SCAN_WORDS - 1));
  assign row_last  = (row == ROW_W'(DRUM_ROWS - 1));
  assign row_wrap  = step && scan_last && row_last;
  assign line_end  = row_wrap && side;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx    <= '0;
      row         <= '0;
      side        <= 1'b0;
      shuttle_req <= 1'b0;
    end else begin
      shuttle_req <= row_wrap;
      if (step) begin
        if (scan_last) begin
          word_idx <= '0;
          if (row_last) begin
            row  <= '0;
            side <= ~side;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          word_idx <= word_idx + 1'b1;
        end
      end
    end
  end

  // R6
  wrap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    row_wrap |=> (row == '0) && (word_idx == '0) && (side != $past(side)));

  // R6
  shuttle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    shuttle_req |=> !shuttle_req);
endmodule

// File: rtl/slp_occupancy.sv
module slp_occupancy #(
  parameter int COLS  = 120,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [COL_W-1:0] set_col,
  input  logic             set_val,
  input  logic             clr,
  input  logic [COL_W-1:0] q_col,
  output logic             q_hit,
  output logic [COL_W-1:0] last_col,
  output logic             any
);
  logic [COLS-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || clr) mask <= '0;
    else if (set_en) mask[set_col] <= set_val;
  end

  assign q_hit = mask[q_col];

  // Highest set column wins: the ascending loop keeps the last hit.
  always_comb begin
    last_col = '0;
    any      = 1'b0;
    for (int i = 0; i < COLS; i++) begin
      if (mask[i]) begin
        last_col = COL_W'(i);
        any      = 1'b1;
      end
    end
  end

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !any);

  // R4
  set_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_val && !clr) |=> any);
endmodule

// File: rtl/shuttle_line_asm.sv
module shuttle_line_asm
  import slp_pkg::*;
#(
  parameter int LINE_COLS = 120,
  parameter int DRUM_ROWS = 64,
  parameter int ROW_W     = (DRUM_ROWS > 1) ? $clog2(DRUM_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  output logic             word_ready,
  output logic             word_skip,
  output logic [ROW_W-1:0] drum_row,
  output logic             carriage,
  output logic             shuttle_req,
  output logic             print_done,
  output logic             out_valid,
  output logic [6:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);
  localparam int SCAN_WORDS = LINE_COLS / 2;
  localparam int WORD_W     = (SCAN_WORDS > 1) ? $clog2(SCAN_WORDS) : 1;
  localparam int COL_W      = WORD_W + 1;

  asm_state_t state, nxt;

  logic              accept, match, line_end;
  logic [WORD_W-1:0] word_idx;
  logic [CODE_W-1:0] code;
  logic [COL_W-1:0]  wcol, idx, last_q, last_col;
  logic [CHAR_W-1:0] wchar, rdata;
  logic              any, q_hit, clr, idx_is_last;
  logic              unused_bits;

  assign unused_bits = ^{word_data[15:14], word_data[7:6]};

  assign accept = word_valid && word_ready;
  assign code   = carriage ? word_data[5:0] : word_data[13:8];
  assign match  = accept && (code == CODE_W'(drum_row));
  assign wcol   = {word_idx, carriage};
  assign wchar  = to_print(code);

  assign idx_is_last = (idx == last_q);
  assign clr = (state == ST_HOLD) && out_ready && idx_is_last;

  slp_scan_ctr #(
    .SCAN_WORDS(SCAN_WORDS), .DRUM_ROWS(DRUM_ROWS),
    .WORD_W(WORD_W), .ROW_W(ROW_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .step(accept),
    .word_idx(word_idx), .row(drum_row), .side(carriage),
    .line_end(line_end), .shuttle_req(shuttle_req)
  );

  slp_line_ram #(.DEPTH(LINE_COLS), .AW(COL_W), .DW(CHAR_W)) u_ram (
    .clk(clk), .we(match), .waddr(wcol), .wdata(wchar),
    .re(state == ST_FETCH), .raddr(idx), .rdata(rdata)
  );

  slp_occupancy #(.COLS(LINE_COLS), .COL_W(COL_W)) u_occ (
    .clk(clk), .rst(rst),
    .set_en(match), .set_col(wcol), .set_val(wchar != BLANK),
    .clr(clr), .q_col(idx), .q_hit(q_hit),
    .last_col(last_col), .any(any)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FILL:  if (line_end) nxt = ST_TRIM;
      ST_TRIM:  nxt = any ? ST_FETCH : ST_FILL;
      ST_FETCH: nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_HOLD;
      ST_HOLD:  if (out_ready) nxt = idx_is_last ? ST_FILL : ST_FETCH;
      default:  nxt = ST_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FILL;
      idx        <= '0;
      last_q     <= '0;
      word_ready <= 1'b0;
      word_skip  <= 1'b0;
      print_done <= 1'b1;
      out_valid  <= 1'b0;
      out_data   <= BLANK;
      out_last   <= 1'b0;
    end else begin
      state      <= nxt;
      word_ready <= (nxt == ST_FILL) && !accept;
      word_skip  <= accept;
      if (accept) print_done <= 1'b0;
      if (((state == ST_TRIM) && !any) || clr) print_done <= 1'b1;
      case (state)
        ST_TRIM: begin
          last_q <= last_col;
          idx    <= '0;
        end
        ST_LOAD: begin
          out_data  <= q_hit ? rdata : BLANK;
          out_last  <= idx_is_last;
          out_valid <= 1'b1;
        end
        ST_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            idx       <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  take_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready);

  // R2
  skip_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
    word_skip |-> $past(word_valid && word_ready));

  // R8
  stream_blocks_host_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !word_ready);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  done_after_stream_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(print_done) |-> !out_valid);
endmodule

// File: tb/shuttle_line_asm_tb.sv
`timescale 1ns/1ps
module shuttle_line_asm_tb;
  localparam int COLS  = 8;
  localparam int ROWS  = 8;
  localparam int RW    = $clog2(ROWS);
  localparam int SCANW = COLS / 2;
  localparam int NV    = 6;

  // Per line: codes for columns 0..7.
  localparam logic [5:0] LINES [NV][COLS] = '{
    '{6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77},
    '{6'o00, 6'o01, 6'o02, 6'o03, 6'o04, 6'o05, 6'o06, 6'o07},
    '{6'o03, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77},
    '{6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o77, 6'o07},
    '{6'o40, 6'o05, 6'o40, 6'o40, 6'o00, 6'o40, 6'o40, 6'o40},
    '{6'o77, 6'o77, 6'o06, 6'o77, 6'o77, 6'o77, 6'o02, 6'o77}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          word_valid = 1'b0;
  logic [15:0]   word_data = '0;
  logic          word_ready, word_skip, carriage, shuttle_req, print_done;
  logic [RW-1:0] drum_row;
  logic          out_valid, out_last;
  logic [6:0]    out_data;
  logic          out_ready = 1'b0;

  int checks = 0, fails = 0, ncap = 0, shuttles = 0, stall_bad = 0, cyc = 0;
  logic [6:0] cap [16];
  logic       capl [16];
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  shuttle_line_asm #(.LINE_COLS(COLS), .DRUM_ROWS(ROWS)) u_dut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .word_skip(word_skip), .drum_row(drum_row),
    .carriage(carriage), .shuttle_req(shuttle_req), .print_done(print_done),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_char(input logic [5:0] c);
    if (c >= 6'(ROWS)) return 7'o040;
    return (c < 6'o40) ? {1'b1, c} : {1'b0, c};
  endfunction

  function automatic int exp_len(input int v);
    int n = 0;
    for (int c = 0; c < COLS; c++)
      if (exp_char(LINES[v][c]) != 7'o040) n = c + 1;
    return n;
  endfunction

  function automatic logic [15:0] word_of(input int v, input int w);
    return {2'b00, LINES[v][2*w], 2'b00, LINES[v][2*w+1]};
  endfunction

  // Downstream sink with a stall every third cycle; records accepted bytes.
  initial begin
    bit         prev_stall = 1'b0;
    logic [6:0] prev_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 3) != 1;
      if (prev_stall && (!out_valid || out_data !== prev_data)) stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (shuttle_req) shuttles++;
      if (out_valid && out_ready && ncap < 16) begin
        cap[ncap]  = out_data;
        capl[ncap] = out_last;
        ncap++;
      end
    end
  end

  task automatic send_word(input logic [15:0] d);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1'b1;
    word_data  = d;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // Offer words during line end; none may be acknowledged (R8).
  task automatic wait_done();
    int skips = 0;
    int n = 0;
    word_valid = 1'b1;
    word_data  = 16'h3F3F;
    while (n < 400) begin
      @(negedge clk);
      if (print_done) break;
      if (word_skip) skips++;
      n++;
    end
    word_valid = 1'b0;
    chk(print_done == 1'b1, "R9", "print_done after line", int'(print_done), 1);
    chk(skips == 0, "R8", "words taken while streaming", skips, 0);
  endtask

  task automatic judge_line(input int v);
    int len = exp_len(v);
    int bad = 0;
    chk(ncap == len, "R7", $sformatf("line %0d length", v), ncap, len);
    for (int i = 0; i < ncap && i < len; i++) begin
      chk(cap[i] == exp_char(LINES[v][i]), "R3 R4 R5",
          $sformatf("line %0d col %0d", v, i), int'(cap[i]), int'(exp_char(LINES[v][i])));
      if (capl[i] != (i == len - 1)) bad++;
    end
    chk(bad == 0, "R7", $sformatf("line %0d last flags", v), bad, 0);
    chk(shuttles == 2, "R6", $sformatf("line %0d shuttle pulses", v), shuttles, 2);
    chk(drum_row == '0 && carriage == 1'b0, "R6", "row and side after line",
        int'({drum_row, carriage}), 0);
    chk(stall_bad == 0, "R8", "output held under stall", stall_bad, 0);
  endtask

  task automatic run_line(input int v);
    bit mid_ok = 1'b1;
    ncap = 0;
    shuttles = 0;
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < ROWS; r++)
        for (int w = 0; w < SCANW; w++) begin
          send_word(word_of(v, w));
          if (print_done) mid_ok = 1'b0;
        end
    chk(mid_ok, "R9", "print_done low during line", int'(mid_ok), 1);
    wait_done();
    judge_line(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(word_ready == 1'b0, "R1", "word_ready in reset", int'(word_ready), 0);
    chk(print_done == 1'b1, "R1", "print_done in reset", int'(print_done), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(drum_row == '0 && carriage == 1'b0, "R1", "counters in reset",
        int'({drum_row, carriage}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(word_ready == 1'b1, "R1", "word_ready after reset", int'(word_ready), 1);

    // Vector table walk; line 3 is the same-cycle store-and-end case (R10).
    for (int v = 0; v < NV; v++) begin
      run_line(v);
      if (v == 3)
        chk(ncap == COLS && cap[COLS-1] == 7'o107, "R10", "final word stored",
            int'(cap[COLS-1]), 7'o107);
    end

    // R2: a word offered while ready is low is ignored.
    ncap = 0;
    shuttles = 0;
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1'b1;
    word_data  = word_of(1, 0);
    @(negedge clk);
    chk(word_ready == 1'b0, "R2", "ready after take", int'(word_ready), 0);
    chk(word_skip == 1'b1, "R2", "skip after take", int'(word_skip), 1);
    word_data = word_of(1, 1);
    @(negedge clk);
    word_valid = 1'b0;
    chk(word_skip == 1'b0, "R2", "skip for ignored word", int'(word_skip), 0);
    for (int k = 1; k < 2 * ROWS * SCANW; k++) begin
      if (k == 2 * ROWS * SCANW - 1) begin
        @(negedge clk);
        chk(word_ready == 1'b1 && print_done == 1'b0, "R2", "line not ended early",
            int'({word_ready, print_done}), 2);
      end
      send_word(word_of(1, k % SCANW));
      if (k == SCANW - 1)
        chk(drum_row == RW'(1), "R6", "row after one scan", int'(drum_row), 1);
    end
    wait_done();
    judge_line(1);

    // R1: reset mid-line blanks the buffer.
    for (int k = 0; k < 10; k++) send_word(word_of(1, k % SCANW));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(print_done == 1'b1 && word_ready == 1'b0, "R1", "mid-line reset flags",
        int'({print_done, word_ready}), 2);
    chk(drum_row == '0 && carriage == 1'b0, "R1", "mid-line reset counters",
        int'({drum_row, carriage}), 0);
    rst = 1'b0;
    run_line(0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule